// File: doc/BRIEF.md
# Sub-dword operand formatter

This block wraps one 32-bit lane of a two-operand ALU so that an instruction can work on a single byte or halfword of its registers. On the operand side, each of the two sources is narrowed to the chosen byte, halfword or full word. The narrowed value is widened back to 32 bits with zero or sign fill, and then given optional absolute-value and negate modifiers. On the result side, the low byte or halfword of the ALU result is placed into a chosen slot of the destination. The other destination bits are cleared, sign-filled, or kept from the old destination value.

All inputs of one instruction arrive as a single beat. That beat carries both raw sources, the old destination, the ALU result for that instruction (computed outside this block) and a 32-bit control word. A flag says whether the instruction has a second source operand. The control-word field positions are fixed, because the instruction decoder upstream packs them. The formatted operands, the merged destination and the clamp request leave as one output beat. The beat is registered when `REG_OUT` is 1, which is the default.

The input and the output are valid/ready streams. A beat is accepted on a clock edge where `in_valid` and `in_ready` are both high. An output beat is consumed on an edge where `out_valid` and `out_ready` are both high. While `out_valid` is high and `out_ready` is low, every output holds its value and `in_ready` is low. This is back-pressure with no skid storage. With `REG_OUT` = 0 the block is purely combinational, and `in_ready` follows `out_ready`.

Top module: `subword_lane_fmt`

## Requirements
- R1: Selector codes pick a part of a word. Codes 0, 1, 2 and 3 pick bits 7:0, 15:8, 23:16 and 31:24. Code 4 picks bits 15:0 and code 5 picks bits 31:16. Code 6 picks the whole word. Without sign-extend, the picked part is zero-extended to 32 bits.
- R2: When the sign-extend bit of a source is set and its selector is not a whole-word code, the picked 8- or 16-bit part is sign-extended to 32 bits. For whole-word selections the bit has no effect.
- R3: After extension, abs is applied first and negate second. Both are 32-bit two's-complement operations, so abs of 0x80000000 stays 0x80000000.
- R4: When `two_src_i` is low, `opb_o` equals `src1_i` unchanged, whatever the source-1 fields hold.
- R5: With fill policy 0, the low byte (selector 0 to 3) or low halfword (selector 4 or 5) of the ALU result is shifted into the selected slot, and every other destination bit is 0.
- R6: With fill policy 1, the inserted part is placed as in R5. The bits above it copy the part's top bit and the bits below it are 0.
- R7: With fill policy 2, the inserted part is placed as in R5, and every other bit equals the same bit of `dst_old_i`.
- R8: With destination selector 6 or 7, `dst_o` equals `alu_res_i` under any fill policy. Source selector 7 behaves as 6. Fill policy 3 behaves as policy 0.
- R9: Control word layout:
  - bits 10:8 hold the destination selector and bits 12:11 the fill policy;
  - bit 13 is the clamp request, copied to `sat_o`;
  - source 0 uses bits 18:16 (selector), 19 (sign-extend), 20 (negate) and 21 (abs);
  - source 1 uses bits 26:24, 27, 28 and 29 for the same four fields.
- R10: With `REG_OUT` = 1, an accepted beat appears at the outputs one clock later. `in_ready` equals `!out_valid || out_ready`. A beat that is stalled holds all outputs stable.
- R11: During and right after reset, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Block can take an input beat |
| src0_i | input | 32 | Raw first source |
| src1_i | input | 32 | Raw second source |
| dst_old_i | input | 32 | Destination register value before the instruction |
| alu_res_i | input | 32 | ALU result for this instruction |
| ctrl_i | input | 32 | Control word (layout in R9) |
| two_src_i | input | 1 | Instruction has a second source operand |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Consumer takes the output beat |
| opa_o | output | 32 | Formatted first operand |
| opb_o | output | 32 | Formatted second operand |
| dst_o | output | 32 | Merged destination value |
| sat_o | output | 1 | Clamp request from the control word |

## Verification
On every accepted beat, the assertions check a set of per-field invariants:
- zero high bits for a plain byte pick;
- result pass-through for whole-word destinations;
- kept and cleared halves under the keep and zero policies;
- the sign copy under sign fill;
- a non-negative result after abs alone;
- the source-1 bypass;
- output stability while stalled.

Exact values for every selector, extend, abs/negate and fill combination on varied data can only be shown by the bench's sweep against its arithmetic model. The same holds for the one-cycle latency and the stall-then-release sequence.

// File: rtl/sdw_pkg.sv
package sdw_pkg;
  localparam int unsigned DW    = 32;
  localparam int unsigned SEL_W = 3;
  localparam int unsigned POL_W = 2;
  localparam int unsigned FLD_W = SEL_W + 3;

  typedef enum logic [SEL_W-1:0] {
    PICK_B0, PICK_B1, PICK_B2, PICK_B3, PICK_HLO, PICK_HHI, PICK_ALL, PICK_RSV
  } pick_e;

  typedef enum logic [POL_W-1:0] {
    FILL_ZERO, FILL_SIGN, FILL_KEEP, FILL_RSV
  } fill_e;

  // Field order matches the packing of each source slot in the control word
  typedef struct packed {
    logic  mag;   // abs
    logic  inv;   // negate
    logic  sext;
    pick_e pick;
  } opnd_fld_t;

  localparam int unsigned DSEL_LSB = 8;
  localparam int unsigned FILL_LSB = 11;
  localparam int unsigned SAT_BIT  = 13;
  localparam int unsigned OPA_LSB  = 16;
  localparam int unsigned OPB_LSB  = 24;

  function automatic logic pick_is_byte(pick_e p);
    return p inside {PICK_B0, PICK_B1, PICK_B2, PICK_B3};
  endfunction

  function automatic logic pick_is_half(pick_e p);
    return p inside {PICK_HLO, PICK_HHI};
  endfunction
endpackage

// File: rtl/sdw_src_extract.sv
module sdw_src_extract
  import sdw_pkg::*;
(
  input  logic [DW-1:0] raw,
  input  opnd_fld_t     fld,
  input  logic          active,
  output logic [DW-1:0] val
);
  logic [7:0]    b_part;
  logic [15:0]   h_part;
  logic [DW-1:0] widened;
  logic [DW-1:0] magn;

  always_comb begin
    b_part = raw[{fld.pick[1:0], 3'b000} +: 8];
    h_part = raw[{fld.pick[0], 4'b0000} +: 16];
    if (pick_is_byte(fld.pick))
      widened = {{(DW-8){fld.sext & b_part[7]}}, b_part};
    else if (pick_is_half(fld.pick))
      widened = {{(DW-16){fld.sext & h_part[15]}}, h_part};
    else
      widened = raw;
    magn = (fld.mag && widened[DW-1]) ? (~widened + 1'b1) : widened;
    if (!active)
      val = raw;
    else if (fld.inv)
      val = ~magn + 1'b1;
    else
      val = magn;
  end
endmodule

// File: rtl/sdw_dst_merge.sv
module sdw_dst_merge
  import sdw_pkg::*;
(
  input  logic [DW-1:0] res,
  input  logic [DW-1:0] old,
  input  pick_e         pick,
  input  fill_e         fill,
  output logic [DW-1:0] merged
);
  logic [4:0]    sh;
  logic [DW-1:0] slot_z;
  logic [DW-1:0] slot_s;
  logic [DW-1:0] slot_m;

  always_comb begin
    if (pick_is_byte(pick)) begin
      sh     = {pick[1:0], 3'b000};
      slot_z = {{(DW-8){1'b0}}, res[7:0]};
      slot_s = {{(DW-8){res[7]}}, res[7:0]};
      slot_m = {{(DW-8){1'b0}}, 8'hFF};
    end else begin
      sh     = {pick[0], 4'b0000};
      slot_z = {{(DW-16){1'b0}}, res[15:0]};
      slot_s = {{(DW-16){res[15]}}, res[15:0]};
      slot_m = {{(DW-16){1'b0}}, 16'hFFFF};
    end
    if (!(pick_is_byte(pick) || pick_is_half(pick)))
      merged = res;
    else begin
      unique case (fill)
        FILL_SIGN: merged = slot_s << sh;
        FILL_KEEP: merged = (old & ~(slot_m << sh)) | (slot_z << sh);
        default:   merged = slot_z << sh;
      endcase
    end
  end
endmodule

// File: rtl/sdw_out_stage.sv
module sdw_out_stage #(
  parameter bit          REG_OUT = 1'b1,
  parameter int unsigned PW      = 97
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [PW-1:0] in_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [PW-1:0] out_data
);
  generate
    if (REG_OUT) begin : g_reg
      logic          vld_q;
      logic [PW-1:0] dat_q;
      assign in_ready  = !vld_q || out_ready;
      assign out_valid = vld_q;
      assign out_data  = dat_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          vld_q <= 1'b0;
          dat_q <= '0;
        end else if (in_ready) begin
          vld_q <= in_valid;
          if (in_valid) dat_q <= in_data;
        end
      end
      AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R10
      AST_READY_RULE: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> !in_ready); // R10
    end else begin : g_comb
      assign in_ready  = out_ready;
      assign out_valid = in_valid;
      assign out_data  = in_data;
    end
  endgenerate
endmodule

// File: rtl/subword_lane_fmt.sv
module subword_lane_fmt
  import sdw_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [31:0]   src0_i,
  input  logic [31:0]   src1_i,
  input  logic [31:0]   dst_old_i,
  input  logic [31:0]   alu_res_i,
  input  logic [31:0]   ctrl_i,
  input  logic          two_src_i,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [31:0]   opa_o,
  output logic [31:0]   opb_o,
  output logic [31:0]   dst_o,
  output logic          sat_o
);
  localparam int unsigned NSRC = 2;
  localparam int unsigned PW   = 3*DW + 1;

  opnd_fld_t     fld   [NSRC];
  logic [DW-1:0] raw   [NSRC];
  logic [DW-1:0] fmt   [NSRC];
  logic          act   [NSRC];
  pick_e         dpick;
  fill_e         dfill;
  logic [DW-1:0] dst_c;
  logic [PW-1:0] pay_in;
  logic [PW-1:0] pay_out;
  logic          unused_ctrl;

  assign fld[0] = opnd_fld_t'(ctrl_i[OPA_LSB +: FLD_W]);
  assign fld[1] = opnd_fld_t'(ctrl_i[OPB_LSB +: FLD_W]);
  assign raw[0] = src0_i;
  assign raw[1] = src1_i;
  assign act[0] = 1'b1;
  assign act[1] = two_src_i;
  assign dpick  = pick_e'(ctrl_i[DSEL_LSB +: SEL_W]);
  assign dfill  = fill_e'(ctrl_i[FILL_LSB +: POL_W]);
  assign unused_ctrl = ^{ctrl_i[7:0], ctrl_i[15:14], ctrl_i[23:22], ctrl_i[31:30]};

  generate
    for (genvar s = 0; s < NSRC; s++) begin : g_src
      sdw_src_extract i_ext (
        .raw    (raw[s]),
        .fld    (fld[s]),
        .active (act[s]),
        .val    (fmt[s])
      );
    end
  endgenerate

  sdw_dst_merge i_merge (
    .res    (alu_res_i),
    .old    (dst_old_i),
    .pick   (dpick),
    .fill   (dfill),
    .merged (dst_c)
  );

  assign pay_in = {ctrl_i[SAT_BIT], dst_c, fmt[1], fmt[0]};

  sdw_out_stage #(.REG_OUT(REG_OUT), .PW(PW)) i_stage (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (pay_in),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (pay_out)
  );

  assign opa_o = pay_out[DW-1:0];
  assign opb_o = pay_out[2*DW-1:DW];
  assign dst_o = pay_out[3*DW-1:2*DW];
  assign sat_o = pay_out[3*DW];

  logic acc;
  assign acc = in_valid && in_ready;

  AST_ZEXT_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && pick_is_byte(fld[0].pick) && !fld[0].sext && !fld[0].mag && !fld[0].inv)
      |-> (fmt[0][DW-1:8] == '0)); // R1
  AST_ABS_NONNEG: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && fld[0].mag && !fld[0].inv && fmt[0] != 32'h8000_0000) |-> !fmt[0][DW-1]); // R3
  AST_B_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !two_src_i) |-> (fmt[1] == src1_i)); // R4
  AST_PAD_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && dfill == FILL_ZERO && dpick == PICK_HHI) |-> (dst_c[15:0] == '0)); // R5
  AST_SIGN_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && dfill == FILL_SIGN && pick_is_byte(dpick)) |-> (dst_c[DW-1] == alu_res_i[7])); // R6
  AST_KEEP_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && dfill == FILL_KEEP && dpick == PICK_HLO) |-> (dst_c[31:16] == dst_old_i[31:16])); // R7
  AST_WORD_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && dpick inside {PICK_ALL, PICK_RSV}) |-> (dst_c == alu_res_i)); // R8
endmodule

// File: tb/test_subword_lane_fmt.sv
module test_subword_lane_fmt;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] src0_i = '0, src1_i = '0, dst_old_i = '0, alu_res_i = '0, ctrl_i = '0;
  logic        two_src_i = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [31:0] opa_o, opb_o, dst_o;
  logic        sat_o;

  int total = 0;
  int bad = 0;
  bit done = 0;

  logic [31:0] exp_a, exp_b, exp_d;
  logic        exp_s;
  string       tag_a, tag_b, tag_d;

  always #2 clk = ~clk;

  subword_lane_fmt i_subword_lane_fmt (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .src0_i(src0_i), .src1_i(src1_i), .dst_old_i(dst_old_i), .alu_res_i(alu_res_i),
    .ctrl_i(ctrl_i), .two_src_i(two_src_i), .out_valid(out_valid), .out_ready(out_ready),
    .opa_o(opa_o), .opb_o(opb_o), .dst_o(dst_o), .sat_o(sat_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mix(input int unsigned s);
    logic [31:0] x;
    x = s * 32'h9E37_79B1 + 32'h7F4A_7C15;
    x = x ^ (x >> 13);
    x = x * 32'h85EB_CA6B;
    return x ^ (x >> 16);
  endfunction

  // reference: part position and width by arithmetic
  function automatic logic [31:0] ref_ext(input logic [31:0] v, input int sel, input bit sx,
                                          input bit ab, input bit ng, input bit on);
    int sh, w;
    logic [31:0] m, x;
    if (!on) return v;
    if (sel < 4) begin sh = 8*sel; w = 8; end
    else if (sel == 4) begin sh = 0; w = 16; end
    else if (sel == 5) begin sh = 16; w = 16; end
    else begin sh = 0; w = 32; end
    m = (w == 32) ? 32'hFFFF_FFFF : ((32'd1 << w) - 1);
    x = (v >> sh) & m;
    if (sx && w < 32 && x[w-1]) x = x | ~m;
    if (ab && x[31]) x = 32'd0 - x;
    if (ng) x = 32'd0 - x;
    return x;
  endfunction

  function automatic logic [31:0] ref_dst(input logic [31:0] r, input logic [31:0] old,
                                          input int sel, input int pol);
    int sh, w;
    logic [31:0] m, p;
    if (sel >= 6) return r;
    if (sel < 4) begin sh = 8*sel; w = 8; end
    else begin sh = (sel == 5) ? 16 : 0; w = 16; end
    m = (32'd1 << w) - 1;
    p = r & m;
    if (pol == 1) begin
      if (p[w-1]) p = p | ~m;
      return p << sh;
    end
    if (pol == 2) return (old & ~(m << sh)) | (p << sh);
    return p << sh;
  endfunction

  function automatic string src_tag(input int sel, input bit sx, input bit ab, input bit ng);
    if (ab || ng) return "R3";
    if (sx) return "R2";
    if (sel == 7) return "R8";
    return "R1";
  endfunction

  function automatic string dst_tag(input int sel, input int pol);
    if (sel >= 6 || pol == 3) return "R8";
    if (pol == 1) return "R6";
    if (pol == 2) return "R7";
    return "R5";
  endfunction

  task automatic drive(input int i, input int j);
    int f1, s0, s1;
    bit sx0, ab0, ng0, sx1, ab1, ng1, two, sat;
    int dsel, pol;
    f1  = (i*5 + j*3) % 64;
    s0  = i % 8; sx0 = i[3]; ng0 = i[4]; ab0 = i[5];
    s1  = f1 % 8; sx1 = f1[3]; ng1 = f1[4]; ab1 = f1[5];
    dsel = j % 8; pol = (j / 8) % 4;
    two = ((i + j) % 3) != 0;
    sat = (i ^ j) & 1;
    src0_i    = mix(i*97 + j);
    src1_i    = mix(i*97 + j + 5000);
    dst_old_i = mix(i*97 + j + 9000);
    alu_res_i = mix(i*97 + j + 13000);
    two_src_i = two;
    // R9 layout: [10:8] dsel, [12:11] fill, [13] clamp, [18:16]/[26:24] sel, +3 sext, +4 neg, +5 abs
    ctrl_i = 32'(dsel) << 8 | 32'(pol) << 11 | 32'(sat) << 13 |
             32'(s0) << 16 | 32'(sx0) << 19 | 32'(ng0) << 20 | 32'(ab0) << 21 |
             32'(s1) << 24 | 32'(sx1) << 27 | 32'(ng1) << 28 | 32'(ab1) << 29 |
             32'hC0C0_C0A5;
    in_valid = 1'b1;
    exp_a = ref_ext(src0_i, s0, sx0, ab0, ng0, 1'b1);
    exp_b = ref_ext(src1_i, s1, sx1, ab1, ng1, two);
    exp_d = ref_dst(alu_res_i, dst_old_i, dsel, pol);
    exp_s = sat;
    tag_a = src_tag(s0, sx0, ab0, ng0);
    tag_b = two ? src_tag(s1, sx1, ab1, ng1) : "R4";
    tag_d = dst_tag(dsel, pol);
  endtask

  task automatic check_out();
    chk("R10 out_valid", {31'd0, out_valid}, 32'd1);
    chk(tag_a, opa_o, exp_a);
    chk(tag_b, opb_o, exp_b);
    chk(tag_d, dst_o, exp_d);
    chk("R9 clamp", {31'd0, sat_o}, {31'd0, exp_s});
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : stim
    logic [31:0] held_d;
    repeat (3) @(negedge clk);
    chk("R11 out_valid in reset", {31'd0, out_valid}, 32'd0);
    chk("R11 in_ready in reset", {31'd0, in_ready}, 32'd1);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11 out_valid after reset", {31'd0, out_valid}, 32'd0);
    out_ready = 1'b1;

    // full sweep of selector/extend/abs/negate and destination/fill codes
    for (int i = 0; i < 64; i++) begin
      for (int j = 0; j < 32; j++) begin
        drive(i, j);
        @(negedge clk);
        check_out();
      end
    end

    // back-pressure: stalled beat holds, next beat waits
    held_d = exp_d;
    out_ready = 1'b0;
    drive(7, 20);
    @(negedge clk);
    chk("R10 in_ready low on stall", {31'd0, in_ready}, 32'd0);
    chk("R10 held dst", dst_o, held_d);
    @(negedge clk);
    chk("R10 still held dst", dst_o, held_d);
    out_ready = 1'b1;
    @(negedge clk);
    check_out();
    in_valid = 1'b0;
    @(negedge clk);
    chk("R10 drained", {31'd0, out_valid}, 32'd0);

    // abs of most negative word wraps (R3)
    in_valid = 1'b1;
    src0_i = 32'h8000_0000; src1_i = 32'h0000_0080; two_src_i = 1'b1;
    ctrl_i = (32'd6 << 16) | (32'd1 << 21) | (32'd0 << 24) | (32'd1 << 27) | (32'd1 << 29) | (32'd6 << 8);
    alu_res_i = 32'h1234_5678; dst_old_i = '0;
    @(negedge clk);
    chk("R3 abs min", opa_o, 32'h8000_0000);
    chk("R3 abs of sext byte", opb_o, 32'h0000_0080);
    chk("R8 word dst", dst_o, 32'h1234_5678);
    in_valid = 1'b0;
    @(negedge clk);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule